// File: doc/BRIEF.md
# UART Host Register and Interrupt Unit

This block is the bus-facing half of a small serial port. A host reaches it over a 32-bit APB slave with a 5-bit word address. Through it the host sets the line format and the baud divisor, masks or unmasks the interrupt sources, and stops or starts the receiver and transmitter. It also pushes bytes to be sent and pops bytes that have arrived. Two byte queues sit between the bus and the serial engines. The transmit queue is drained by the transmitter through a pop strobe. The receive queue is filled by the receiver through a push strobe.

The serial engines report finished frames and framing faults as one-cycle pulses. The unit latches these pulses into sticky flags, together with a receive-queue-filled flag and a transmit-queue-drained flag, and drives one active-low interrupt line. Writing a one to a self-clearing bit of the enable register produces a single-cycle soft reset pulse. That pulse empties both queues and all latched flags but leaves the configuration in place. Serial framing and baud timing are handled outside this unit.

Top module: `uart_apb_regs`

## Requirements
- R1: After rst_ni is released, the registers read as follows: line control 0, enable 0x3F, baud divisor 0, status 0x20. irq_no is 1, tx_valid_o is 0 and soft_rst_o is 0.
- R2: A register is written only in a cycle where psel_i, penable_i and pwrite_i are all 1. Reads are combinational while psel_i=1 and pwrite_i=0. Register behaviour by address: 0x00 holds line control bits [5:0] and reads them back. 0x01 holds enable bits [8:7] and [5:0], and bit 6 always reads 0. 0x02 holds the full 32-bit baud divisor. Address 0x05 and any unmapped address read 0.
- R3: A write to 0x05 queues pwdata_i[7:0] at the tail of a 4-entry transmit queue, and a write while the queue holds 4 bytes is dropped. tx_valid_o is 1 while the queue is non-empty, and tx_data_o shows the oldest byte. A tx_pop_i pulse removes the oldest byte. Status bit 6 reads 1 while the queue is full.
- R4: A rx_push_i pulse stores rx_data_i in a 4-entry receive queue, and a push while the queue is full is dropped. A read access of 0x04 returns the oldest byte and removes it. A read of 0x04 while the queue is empty returns 0. Status bit 5 reads 1 while the queue is empty.
- R5: Status bits 0 to 3 latch the pulses rx_done_evt_i, tx_done_evt_i, parity_err_evt_i and stop_err_evt_i, in that order. Writing 0 to one of these bits at 0x03 clears it, and writing 1 leaves it unchanged. A pulse in the same cycle as a clearing write leaves the bit set.
- R6: Status bit 4 sets when a push brings the receive queue to 4 entries. Any read access of 0x04 clears it.
- R7: Status bit 7 sets when a tx_pop_i pulse removes the last byte of the transmit queue. Any write to 0x05 clears it.
- R8: irq_no is 0 exactly when some latched flag has its mask bit at 0. Mask bits 0 to 3 guard status bits 0 to 3, mask bit 4 guards status bit 4, and mask bit 5 guards status bit 7.
- R9: A write to 0x01 with bit 6 = 1 drives soft_rst_o to 1 for the next cycle only. During that cycle both queues and all latched flags are cleared. Line control, baud divisor and the other enable bits keep the values just written.
- R10: word_sel_o, stop_sel_o and parity_sel_o show line control bits [1:0], [3:2] and [5:4]. rx_halt_o shows enable bit 7 and tx_halt_o shows enable bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write (1) or read (0) |
| paddr_i | input | 5 | APB word address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| irq_no | output | 1 | Interrupt, active low |
| word_sel_o | output | 2 | Word length select to the serial engines |
| stop_sel_o | output | 2 | Stop length select |
| parity_sel_o | output | 2 | Parity select |
| baud_div_o | output | 32 | Baud divisor |
| rx_halt_o | output | 1 | Receiver stop request |
| tx_halt_o | output | 1 | Transmitter stop request |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| tx_valid_o | output | 1 | Transmit queue non-empty |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_pop_i | input | 1 | Transmitter takes oldest byte |
| rx_push_i | input | 1 | Receiver delivers a byte |
| rx_data_i | input | 8 | Received byte |
| rx_done_evt_i | input | 1 | Frame received pulse |
| tx_done_evt_i | input | 1 | Frame sent pulse |
| parity_err_evt_i | input | 1 | Parity fault pulse |
| stop_err_evt_i | input | 1 | Stop bit fault pulse |

## Verification
The flag and queue logic is driven with a random mix of bus writes and reads, engine pushes and pops, and combined event pulses. After each step the status word and the interrupt line are compared against a model. This separates sticky event flags from live queue levels, and it catches flags that set on the wrong queue transition. Directed sequences cover the remaining cases. Queues are filled past capacity to show that surplus bytes are dropped and that FIFO order holds. The receive queue is read while empty. A clearing write is made to collide with an event pulse to show that the set wins. A write with only the setup phase is made to show that the access phase is required. A soft reset is issued with data in both queues, to tell flushed state apart from configuration that is kept.

// File: rtl/uart_apb_pkg.sv
package uart_apb_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_LINE = 5'h00;
  localparam logic [ADDR_W-1:0] A_ENBL = 5'h01;
  localparam logic [ADDR_W-1:0] A_BAUD = 5'h02;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h03;
  localparam logic [ADDR_W-1:0] A_RXD  = 5'h04;
  localparam logic [ADDR_W-1:0] A_TXD  = 5'h05;

  localparam int N_FLAGS   = 6;
  localparam int F_RXDONE  = 0;
  localparam int F_TXDONE  = 1;
  localparam int F_PARERR  = 2;
  localparam int F_STOPERR = 3;
  localparam int F_RXFULL  = 4;
  localparam int F_TXEMPTY = 5;

  localparam int ENBL_W  = 9;
  localparam int B_SRST  = 6;
  localparam int B_RXHLT = 7;
  localparam int B_TXHLT = 8;

  typedef struct packed {
    logic [1:0] parity;
    logic [1:0] stop;
    logic [1:0] word;
  } line_ctrl_t;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == FULLC);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_q];
  assign push_ok = push_i && !full_o && !clear_i;
  assign pop_ok  = pop_i && !empty_o && !clear_i;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i) |=> (count_o == FULLC));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clear_i) |=> empty_o);
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;

    // soft clear > hardware set > software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q <= 1'b0;
      else if (clr_all_i)    flag_q <= 1'b0;
      else if (set_i[g])     flag_q <= 1'b1;
      else if (clr_i[g])     flag_q <= 1'b0;
    end
    assign flags_o[g] = flag_q;

    assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[g] && !clr_all_i) |=> flags_o[g]);

    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
  end
endmodule

// File: rtl/uart_apb_regs.sv
module uart_apb_regs
  import uart_apb_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  output logic              irq_no,
  output logic [1:0]        word_sel_o,
  output logic [1:0]        stop_sel_o,
  output logic [1:0]        parity_sel_o,
  output logic [BUS_W-1:0]  baud_div_o,
  output logic              rx_halt_o,
  output logic              tx_halt_o,
  output logic              soft_rst_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_pop_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_done_evt_i,
  input  logic              tx_done_evt_i,
  input  logic              parity_err_evt_i,
  input  logic              stop_err_evt_i
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] ALMOST = CW'(FIFO_DEPTH - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [ENBL_W-1:0] ENBL_RST = ENBL_W'(9'h03F);

  line_ctrl_t        line_q;
  logic [ENBL_W-1:0] enbl_q;
  logic [BUS_W-1:0]  baud_q;
  logic              srst_q;

  logic wr_en, rd_acc;
  logic wr_line, wr_enbl, wr_baud, wr_stat, wr_txd, rd_rxd;

  logic [DATA_W-1:0] rx_head;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic [CW-1:0]     rx_cnt, tx_cnt;

  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

  assign wr_en   = psel_i && penable_i && pwrite_i;
  assign rd_acc  = psel_i && penable_i && !pwrite_i;
  assign wr_line = wr_en && (paddr_i == A_LINE);
  assign wr_enbl = wr_en && (paddr_i == A_ENBL);
  assign wr_baud = wr_en && (paddr_i == A_BAUD);
  assign wr_stat = wr_en && (paddr_i == A_STAT);
  assign wr_txd  = wr_en && (paddr_i == A_TXD);
  assign rd_rxd  = rd_acc && (paddr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      enbl_q <= ENBL_RST;
      baud_q <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= wr_enbl && pwdata_i[B_SRST];
      if (wr_line) line_q <= pwdata_i[5:0];
      if (wr_enbl) enbl_q <= {pwdata_i[B_TXHLT:B_RXHLT], 1'b0, pwdata_i[5:0]};
      if (wr_baud) baud_q <= pwdata_i;
    end
  end

  uart_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (srst_q),
    .push_i  (wr_txd),
    .data_i  (pwdata_i[DATA_W-1:0]),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .full_o  (tx_full),
    .empty_o (tx_empty),
    .count_o (tx_cnt)
  );

  uart_byte_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (srst_q),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rd_rxd),
    .data_o  (rx_head),
    .full_o  (rx_full),
    .empty_o (rx_empty),
    .count_o (rx_cnt)
  );

  always_comb begin
    flag_set            = '0;
    flag_clr            = '0;
    flag_set[F_RXDONE]  = rx_done_evt_i;
    flag_set[F_TXDONE]  = tx_done_evt_i;
    flag_set[F_PARERR]  = parity_err_evt_i;
    flag_set[F_STOPERR] = stop_err_evt_i;
    // queue-level flags fire on the transition, not the level
    flag_set[F_RXFULL]  = rx_push_i && (rx_cnt == ALMOST) && !rd_rxd;
    flag_set[F_TXEMPTY] = tx_pop_i && (tx_cnt == ONE) && !wr_txd;
    for (int k = 0; k <= F_STOPERR; k++) flag_clr[k] = wr_stat && !pwdata_i[k];
    flag_clr[F_RXFULL]  = rd_rxd;
    flag_clr[F_TXEMPTY] = wr_txd;
  end

  uart_flag_bank #(.N(N_FLAGS)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (srst_q),
    .set_i     (flag_set),
    .clr_i     (flag_clr),
    .flags_o   (flags)
  );

  assign irq_no = ~|(flags & ~enbl_q[N_FLAGS-1:0]);

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      case (paddr_i)
        A_LINE:  prdata_o = BUS_W'(line_q);
        A_ENBL:  prdata_o = BUS_W'(enbl_q);
        A_BAUD:  prdata_o = baud_q;
        A_STAT:  prdata_o = BUS_W'({flags[F_TXEMPTY], tx_full, rx_empty, flags[F_RXFULL],
                                    flags[F_STOPERR:F_RXDONE]});
        A_RXD:   prdata_o = rx_empty ? '0 : BUS_W'(rx_head);
        default: prdata_o = '0;
      endcase
    end
  end

  assign word_sel_o   = line_q.word;
  assign stop_sel_o   = line_q.stop;
  assign parity_sel_o = line_q.parity;
  assign baud_div_o   = baud_q;
  assign rx_halt_o    = enbl_q[B_RXHLT];
  assign tx_halt_o    = enbl_q[B_TXHLT];
  assign soft_rst_o   = srst_q;
  assign tx_valid_o   = !tx_empty;

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(baud_q) && $stable(line_q) && $stable(enbl_q)));

  assert_srst_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (rx_cnt == '0 && tx_cnt == '0 && flags == '0));
endmodule

// File: tb/sim_uart_apb_regs.sv
`timescale 1ns/1ps
module sim_uart_apb_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_n;
  logic [1:0]  word_sel, stop_sel, par_sel;
  logic [31:0] baud;
  logic        rx_halt, tx_halt, srst, tx_valid;
  logic [7:0]  tx_data;
  logic        tx_pop = 0, rx_push = 0;
  logic [7:0]  rx_data = '0;
  logic [3:0]  evt = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] tq[$];
  logic [7:0] rq[$];
  logic [5:0] mflags = '0;
  logic [5:0] mmask = 6'h3F;

  always #4 clk = ~clk;

  uart_apb_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .irq_no(irq_n),
    .word_sel_o(word_sel), .stop_sel_o(stop_sel), .parity_sel_o(par_sel),
    .baud_div_o(baud), .rx_halt_o(rx_halt), .tx_halt_o(tx_halt), .soft_rst_o(srst),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_pop_i(tx_pop),
    .rx_push_i(rx_push), .rx_data_i(rx_data),
    .rx_done_evt_i(evt[0]), .tx_done_evt_i(evt[1]),
    .parity_err_evt_i(evt[2]), .stop_err_evt_i(evt[3])
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [31:0] exp_status();
    return {24'h0, mflags[5], (tq.size() == 4), (rq.size() == 0), mflags[4], mflags[3:0]};
  endfunction

  function automatic logic exp_irq_n();
    return ~|(mflags & ~mmask);
  endfunction

  task automatic op_tx_write(input logic [7:0] b);
    apb_write(5'h05, {24'hA5A5A5, b});
    if (tq.size() < 4) tq.push_back(b);
    mflags[5] = 1'b0;
  endtask

  task automatic op_rx_read();
    logic [31:0] d;
    logic [31:0] e;
    e = (rq.size() > 0) ? {24'h0, rq[0]} : 32'h0;
    apb_read(5'h04, d);
    chk("R4 rx read data", d, e);
    if (rq.size() > 0) void'(rq.pop_front());
    mflags[4] = 1'b0;
  endtask

  task automatic op_rx_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_data = b;
    @(negedge clk); rx_push = 0;
    if (rq.size() < 4) begin
      rq.push_back(b);
      if (rq.size() == 4) mflags[4] = 1'b1;
    end
  endtask

  task automatic op_tx_pop();
    @(negedge clk);
    chk("R3 tx_valid", {31'h0, tx_valid}, {31'h0, tq.size() > 0});
    if (tq.size() > 0) chk("R3 tx head", {24'h0, tx_data}, {24'h0, tq[0]});
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    if (tq.size() > 0) begin
      void'(tq.pop_front());
      if (tq.size() == 0) mflags[5] = 1'b1;
    end
  endtask

  task automatic op_evt(input logic [3:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    mflags[3:0] = mflags[3:0] | v;
  endtask

  task automatic op_stat_wr(input logic [3:0] v);
    apb_write(5'h03, {28'hFFFFFFF, v});
    mflags[3:0] = mflags[3:0] & v;
  endtask

  task automatic op_mask(input logic [5:0] m, input logic [1:0] h);
    apb_write(5'h01, {23'h0, h, 1'b0, m});
    mmask = m;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    apb_read(5'h03, d);
    chk(tag, d, exp_status());
    chk("R8 irq_no", {31'h0, irq_n}, {31'h0, exp_irq_n()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    apb_read(5'h00, d); chk("R1 line ctrl", d, 32'h0);
    apb_read(5'h01, d); chk("R1 enable", d, 32'h3F);
    apb_read(5'h02, d); chk("R1 baud", d, 32'h0);
    apb_read(5'h03, d); chk("R1 status", d, 32'h20);
    chk("R1 irq_no", {31'h0, irq_n}, 32'h1);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R1 soft_rst", {31'h0, srst}, 32'h0);

    // R2 register access
    apb_write(5'h00, 32'hFFFF_FFE6);
    apb_read(5'h00, d); chk("R2 line ctrl", d, 32'h26);
    chk("R10 word_sel", {30'h0, word_sel}, 32'h2);
    chk("R10 stop_sel", {30'h0, stop_sel}, 32'h1);
    chk("R10 parity_sel", {30'h0, par_sel}, 32'h2);
    apb_write(5'h02, 32'hDEAD_BEEF);
    apb_read(5'h02, d); chk("R2 baud", d, 32'hDEAD_BEEF);
    chk("R2 baud out", baud, 32'hDEAD_BEEF);
    @(negedge clk); psel = 1; pwrite = 1; paddr = 5'h02; pwdata = 32'h1234_5678;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_read(5'h02, d); chk("R2 setup-only no write", d, 32'hDEAD_BEEF);
    apb_read(5'h07, d); chk("R2 unmapped", d, 32'h0);
    apb_read(5'h1F, d); chk("R2 unmapped top", d, 32'h0);
    apb_read(5'h05, d); chk("R2 tx port reads 0", d, 32'h0);
    op_mask(6'h3F, 2'b10);
    apb_read(5'h01, d); chk("R2 enable", d, 32'h13F);
    chk("R10 rx_halt", {31'h0, rx_halt}, 32'h0);
    chk("R10 tx_halt", {31'h0, tx_halt}, 32'h1);
    op_mask(6'h3F, 2'b01);
    chk("R10 rx_halt set", {31'h0, rx_halt}, 32'h1);
    chk("R10 tx_halt clr", {31'h0, tx_halt}, 32'h0);
    op_mask(6'h00, 2'b00);

    // R3 / R7 transmit queue to overflow and back
    for (int i = 0; i < 5; i++) op_tx_write(8'h10 + 8'(i));
    check_state("R3 tx full status");
    for (int i = 0; i < 5; i++) op_tx_pop();
    check_state("R7 tx drained flag");
    op_tx_write(8'h77);
    check_state("R7 cleared by tx write");
    op_tx_pop();

    // R4 / R6 receive queue
    for (int i = 0; i < 5; i++) op_rx_push(8'hC0 + 8'(i));
    check_state("R6 rx full flag");
    for (int i = 0; i < 5; i++) op_rx_read();
    check_state("R4 rx empty");

    // R5 set beats clear in same cycle, write of 1 keeps flag
    op_evt(4'b1011);
    op_stat_wr(4'b1111);
    check_state("R5 write 1 no effect");
    @(negedge clk); psel = 1; pwrite = 1; paddr = 5'h03; pwdata = 32'h0;
    @(negedge clk); penable = 1; evt = 4'b0100;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; evt = '0;
    mflags[3:0] = 4'b0100;
    check_state("R5 set wins over clear");
    op_stat_wr(4'b0000);
    check_state("R5 cleared");

    // random mix
    op_mask(6'($urandom()), 2'b00);
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 6))
        0: op_tx_write(8'($urandom()));
        1: op_tx_pop();
        2: op_rx_push(8'($urandom()));
        3: op_rx_read();
        4: op_evt(4'($urandom()));
        5: op_stat_wr(4'($urandom()));
        default: op_mask(6'($urandom()), 2'($urandom()));
      endcase
      check_state("R5/R6/R7 status");
    end

    // R9 soft reset
    op_mask(6'h00, 2'b00);
    op_tx_write(8'h11); op_tx_write(8'h22);
    op_rx_push(8'h33); op_rx_push(8'h44);
    op_evt(4'hF);
    apb_write(5'h01, 32'h0000_0040);
    chk("R9 soft_rst pulse", {31'h0, srst}, 32'h1);
    @(negedge clk);
    chk("R9 soft_rst one cycle", {31'h0, srst}, 32'h0);
    chk("R9 tx flushed", {31'h0, tx_valid}, 32'h0);
    chk("R9 irq released", {31'h0, irq_n}, 32'h1);
    tq.delete(); rq.delete(); mflags = '0; mmask = '0;
    apb_read(5'h03, d); chk("R9 status after flush", d, 32'h20);
    apb_read(5'h01, d); chk("R9 enable kept", d, 32'h0);
    apb_read(5'h00, d); chk("R9 line kept", d, 32'h26);
    apb_read(5'h02, d); chk("R9 baud kept", d, 32'hDEAD_BEEF);
    apb_read(5'h04, d); chk("R9 rx empty read", d, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule